// File: doc/BRIEF.md
# 2D Mesh XY Packet Router

This block is the switch for one node of a square two-dimensional mesh with side `K`. It has five ports: the local node, the neighbour in the positive X direction, the neighbour in negative X, the neighbour in positive Y and the neighbour in negative Y. Every packet is one flit long. Each flit holds the destination coordinates and a payload. Every input and every output uses a valid/ready handshake.

A flit that arrives on an input is stored in that input's small FIFO. The route for the flit at the head of each FIFO is worked out from the signed difference between its destination and this node's own coordinates, which are parameters. The X difference is corrected first, and only after that the Y difference. Each output has a round-robin arbiter, and a crossbar mux connects the granted FIFO head to the output.

Each input FIFO is a state machine with three states:
- `FQ_EMPTY` moves to `FQ_PART` when the count rises.
- `FQ_PART` moves to `FQ_FULL` when the count reaches the depth.
- `FQ_PART` moves back to `FQ_EMPTY` when the count drops to zero.
- `FQ_FULL` moves back to `FQ_PART` when a pop is not matched by a push.

Each output arbiter is a state machine with two states:
- `ARB_OPEN` chooses a requester by rotating priority. It moves to `ARB_LOCK` when its pick is offered but the downstream side is not ready.
- `ARB_LOCK` keeps the held grant and moves back to `ARB_OPEN` in the cycle the held flit is accepted.

Top module: `mesh_xy_router`

## Requirements
- R1: After reset, every `out_valid` bit is 0 and every `in_ready` bit is 1.
- R2: A flit is `{dest_x[CW-1:0], dest_y[CW-1:0], payload[PAY_W-1:0]}`, with `dest_x` in the top bits. Port index 0 is local, 1 is +X, 2 is −X, 3 is +Y and 4 is −Y. If `dest_x` is greater than `MY_X`, the flit leaves on port 1. If it is less, the flit leaves on port 2.
- R3: If `dest_x` equals `MY_X`, the flit leaves on port 3 when `dest_y` is greater than `MY_Y`, on port 4 when it is less, and on port 0 when the two are equal.
- R4: The block accepts legal traffic only: a flit on a Y input already has `dest_x == MY_X`, and no flit's route points back out of the port it came in on. For such traffic, no flit leaves by the port it arrived on, and no flit on a Y input (3 or 4) ever goes to an X output.
- R5: A flit accepted at a clock edge is offered on its output from the next cycle, with its contents unchanged. It leaves the block at the first edge where that output is ready.
- R6: When several FIFO heads want the same output, exactly one of them is offered in a cycle. The others stay queued.
- R7: Output priority rotates: after input i is granted, the search starts at input i+1 (mod 5). The pointer starts at input 0 after reset.
- R8: While an output has `out_valid` set and `out_ready` low, it keeps offering the same flit, even if another request of higher priority arrives.
- R9: A full input FIFO drives `in_ready` low. No flit is lost, and each input delivers its flits in order.
- R10: Different outputs transfer flits from different inputs in the same cycle. An input FIFO can accept and release a flit in the same cycle, so each input sustains one flit per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 5 | Flit offered on each input port |
| in_ready | output | 5 | Input FIFO has room |
| in_data | input | 5*FW | Flit on each input port, port p at bits [p*FW +: FW] |
| out_valid | output | 5 | Flit offered on each output port |
| out_ready | input | 5 | Downstream side accepts the flit |
| out_data | output | 5*FW | Flit on each output port, port p at bits [p*FW +: FW] |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a push and a pop on the same input FIFO. It is provoked by streaming a new flit into inputs 0 and 1 on every cycle while both of their outputs stay ready. The test is judged by `in_ready` staying high and by every flit appearing exactly one cycle after it entered. During that same stream, two outputs carry flits together, which covers concurrent transfers (R10).

The second pair is a new, higher-priority request arriving while an output is stalled and locked. It is provoked by holding the local output not-ready, queueing input 2 first and then input 1. The test is judged by the stalled flit staying in place and by the release order of 2, 1, 2, 1, which only rotating priority produces.

// File: rtl/mesh_pkg.sv
package mesh_pkg;

    localparam int NPORT      = 5;
    localparam int PORT_LOCAL = 0;
    localparam int PORT_XPOS  = 1;
    localparam int PORT_XNEG  = 2;
    localparam int PORT_YPOS  = 3;
    localparam int PORT_YNEG  = 4;

    typedef enum logic [1:0] {
        FQ_EMPTY = 2'd0,
        FQ_PART  = 2'd1,
        FQ_FULL  = 2'd2
    } fq_state_e;

    typedef enum logic {
        ARB_OPEN = 1'b0,
        ARB_LOCK = 1'b1
    } arb_state_e;

endpackage

// File: rtl/mesh_in_fifo.sv
module mesh_in_fifo
    import mesh_pkg::*;
#(
    parameter int W     = 12,
    parameter int DEPTH = 2,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_valid,
    output logic         push_ready,
    input  logic [W-1:0] push_data,
    output logic         head_valid,
    output logic [W-1:0] head_data,
    input  logic         pop
);

    fq_state_e        state_q, state_d;
    logic [W-1:0]     mem [DEPTH];
    logic [AW-1:0]    wr_q, rd_q;
    logic [CNTW-1:0]  cnt_q, cnt_d;
    logic             do_push, do_pop;

    assign do_push   = push_valid && push_ready;
    assign do_pop    = pop && head_valid;
    assign head_data = mem[rd_q];

    // next count and next state
    always_comb begin
        unique case ({do_push, do_pop})
            2'b10:   cnt_d = cnt_q + CNTW'(1);
            2'b01:   cnt_d = cnt_q - CNTW'(1);
            default: cnt_d = cnt_q;
        endcase
        if (cnt_d == '0)
            state_d = FQ_EMPTY;
        else if (cnt_d == CNTW'(DEPTH))
            state_d = FQ_FULL;
        else
            state_d = FQ_PART;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FQ_EMPTY;
            cnt_q   <= '0;
            wr_q    <= '0;
            rd_q    <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (do_push)
                wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + AW'(1);
            if (do_pop)
                rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + AW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push)
            mem[wr_q] <= push_data;
    end

    // outputs per state
    always_comb begin
        unique case (state_q)
            FQ_EMPTY: begin push_ready = 1'b1; head_valid = 1'b0; end
            FQ_PART:  begin push_ready = 1'b1; head_valid = 1'b1; end
            FQ_FULL:  begin push_ready = 1'b0; head_valid = 1'b1; end
            default:  begin push_ready = 1'b0; head_valid = 1'b0; end
        endcase
    end

    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNTW'(DEPTH));

    a_r9_push_counts: assert property (@(posedge clk) disable iff (!rst_n)
        do_push && !do_pop |=> cnt_q == $past(cnt_q) + CNTW'(1));

    a_r10_push_pop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        do_push && do_pop |=> cnt_q == $past(cnt_q));

endmodule

// File: rtl/mesh_xy_route.sv
module mesh_xy_route
    import mesh_pkg::*;
#(
    parameter int K    = 4,
    parameter int MY_X = 1,
    parameter int MY_Y = 2,
    localparam int CW  = $clog2(K)
) (
    input  logic [CW-1:0]    dst_x,
    input  logic [CW-1:0]    dst_y,
    output logic [NPORT-1:0] want
);

    localparam logic [CW-1:0] HOME_X = CW'(MY_X);
    localparam logic [CW-1:0] HOME_Y = CW'(MY_Y);

    // X offset is cleared fully before Y is considered
    always_comb begin
        want = '0;
        if (dst_x > HOME_X)
            want[PORT_XPOS] = 1'b1;
        else if (dst_x < HOME_X)
            want[PORT_XNEG] = 1'b1;
        else if (dst_y > HOME_Y)
            want[PORT_YPOS] = 1'b1;
        else if (dst_y < HOME_Y)
            want[PORT_YNEG] = 1'b1;
        else
            want[PORT_LOCAL] = 1'b1;
    end

endmodule

// File: rtl/mesh_out_arb.sv
module mesh_out_arb
    import mesh_pkg::*;
#(
    parameter int N     = NPORT,
    localparam int PTRW = (N > 1) ? $clog2(N) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         out_ready,
    output logic [N-1:0] grant,
    output logic         fire
);

    arb_state_e      state_q, state_d;
    logic [N-1:0]    pick, held_q;
    logic [PTRW-1:0] ptr_q, ptr_d;
    logic            found;

    // rotating-priority pick, search starts at ptr_q
    always_comb begin
        pick  = '0;
        found = 1'b0;
        for (int off = 0; off < N; off++) begin
            for (int i = 0; i < N; i++) begin
                if (!found && req[i] && (i == (int'(ptr_q) + off) % N)) begin
                    pick[i] = 1'b1;
                    found   = 1'b1;
                end
            end
        end
    end

    // next state
    always_comb begin
        unique case (state_q)
            ARB_OPEN: state_d = (|pick && !out_ready) ? ARB_LOCK : ARB_OPEN;
            ARB_LOCK: state_d = out_ready ? ARB_OPEN : ARB_LOCK;
            default:  state_d = ARB_OPEN;
        endcase
    end

    // outputs per state
    always_comb begin
        unique case (state_q)
            ARB_OPEN: grant = pick;
            ARB_LOCK: grant = held_q;
            default:  grant = '0;
        endcase
        fire = (|grant) && out_ready;
    end

    always_comb begin
        ptr_d = ptr_q;
        if (fire) begin
            for (int i = 0; i < N; i++) begin
                if (grant[i])
                    ptr_d = PTRW'((i + 1) % N);
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_OPEN;
            held_q  <= '0;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
            if (state_q == ARB_OPEN)
                held_q <= pick;
        end
    end

    a_r6_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    a_r6_grant_requested: assert property (@(posedge clk) disable iff (!rst_n)
        |grant |-> (grant & ~req) == '0);

    a_r8_hold_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant && !out_ready) |=> grant == $past(grant));

    a_r8_lock_has_req: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ARB_LOCK |-> |(req & held_q));

endmodule

// File: rtl/mesh_xy_router.sv
module mesh_xy_router
    import mesh_pkg::*;
#(
    parameter int K          = 4,
    parameter int MY_X       = 1,
    parameter int MY_Y       = 2,
    parameter int PAY_W      = 8,
    parameter int FIFO_DEPTH = 2,
    localparam int CW        = $clog2(K),
    localparam int FW        = 2 * CW + PAY_W,
    localparam int BUS_W     = NPORT * FW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPORT-1:0] in_valid,
    output logic [NPORT-1:0] in_ready,
    input  logic [BUS_W-1:0] in_data,
    output logic [NPORT-1:0] out_valid,
    input  logic [NPORT-1:0] out_ready,
    output logic [BUS_W-1:0] out_data
);

    logic [NPORT-1:0] head_valid;
    logic [FW-1:0]    head_flit [NPORT];
    logic [NPORT-1:0] want      [NPORT];
    logic [NPORT-1:0] req_to    [NPORT];
    logic [NPORT-1:0] gnt       [NPORT];
    logic [NPORT-1:0] fire_o;
    logic [NPORT-1:0] pop;

    for (genvar gi = 0; gi < NPORT; gi++) begin : g_in
        mesh_in_fifo #(.W(FW), .DEPTH(FIFO_DEPTH)) u_fifo (
            .clk        (clk),
            .rst_n      (rst_n),
            .push_valid (in_valid[gi]),
            .push_ready (in_ready[gi]),
            .push_data  (in_data[gi*FW +: FW]),
            .head_valid (head_valid[gi]),
            .head_data  (head_flit[gi]),
            .pop        (pop[gi])
        );

        mesh_xy_route #(.K(K), .MY_X(MY_X), .MY_Y(MY_Y)) u_route (
            .dst_x (head_flit[gi][FW-1 -: CW]),
            .dst_y (head_flit[gi][PAY_W +: CW]),
            .want  (want[gi])
        );

        a_r2_single_route: assert property (@(posedge clk) disable iff (!rst_n)
            head_valid[gi] |-> $onehot(want[gi]));

        a_r4_no_uturn: assert property (@(posedge clk) disable iff (!rst_n)
            head_valid[gi] |-> !want[gi][gi]);

        if (gi == PORT_YPOS || gi == PORT_YNEG) begin : g_ychk
            a_r4_no_y_to_x: assert property (@(posedge clk) disable iff (!rst_n)
                head_valid[gi] |-> !want[gi][PORT_XPOS] && !want[gi][PORT_XNEG]);
        end
    end

    // transpose head requests into per-output request vectors; gather pops
    always_comb begin
        for (int o = 0; o < NPORT; o++) begin
            for (int i = 0; i < NPORT; i++) begin
                req_to[o][i] = head_valid[i] && want[i][o];
            end
        end
        for (int i = 0; i < NPORT; i++) begin
            pop[i] = 1'b0;
            for (int o = 0; o < NPORT; o++) begin
                pop[i] = pop[i] | (gnt[o][i] & fire_o[o]);
            end
        end
    end

    for (genvar go = 0; go < NPORT; go++) begin : g_out
        logic [FW-1:0] sel;

        mesh_out_arb #(.N(NPORT)) u_arb (
            .clk       (clk),
            .rst_n     (rst_n),
            .req       (req_to[go]),
            .out_ready (out_ready[go]),
            .grant     (gnt[go]),
            .fire      (fire_o[go])
        );

        always_comb begin
            sel = '0;
            for (int i = 0; i < NPORT; i++) begin
                if (gnt[go][i])
                    sel = sel | head_flit[i];
            end
        end

        assign out_data[go*FW +: FW] = sel;
        assign out_valid[go]         = |gnt[go];

        a_r8_stable_data: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[go] && !out_ready[go] |=> out_valid[go] && $stable(out_data[go*FW +: FW]));
    end

    a_r9_pop_only_head: assert property (@(posedge clk) disable iff (!rst_n)
        (pop & ~head_valid) == '0);

endmodule

// File: tb/mesh_xy_router_test.sv
module mesh_xy_router_test;

    localparam int CLK_P = 10;
    localparam int K     = 4;
    localparam int MX    = 1;
    localparam int MY    = 2;
    localparam int PW    = 8;
    localparam int DEP   = 2;
    localparam int CW    = 2;
    localparam int FW    = 2 * CW + PW;
    localparam int NP    = 5;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [NP-1:0]   in_valid, in_ready, out_valid, out_ready;
    logic [NP*FW-1:0] in_data, out_data;

    int total = 0;
    int bad   = 0;

    always #(CLK_P / 2) clk = ~clk;

    mesh_xy_router #(.K(K), .MY_X(MX), .MY_Y(MY), .PAY_W(PW), .FIFO_DEPTH(DEP)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [FW-1:0] act, input logic [FW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [FW-1:0] mk(input int x, input int y, input int p);
        return {CW'(x), CW'(y), PW'(p)};
    endfunction

    function automatic logic [FW-1:0] outf(input int e);
        return out_data[e*FW +: FW];
    endfunction

    function automatic int exp_port(input int x, input int y);
        if (x > MX) return 1;
        if (x < MX) return 2;
        if (y > MY) return 3;
        if (y < MY) return 4;
        return 0;
    endfunction

    function automatic bit legal(input int p, input int x, input int y);
        case (p)
            0:       return !(x == MX && y == MY);
            1:       return x <= MX;
            2:       return x >= MX;
            3:       return x == MX && y <= MY;
            default: return x == MX && y >= MY;
        endcase
    endfunction

    task automatic put(input int p, input logic [FW-1:0] f);
        in_data[p*FW +: FW] = f;
        in_valid[p]         = 1'b1;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [FW-1:0] f0, f1, f2;
        logic [FW-1:0] order [4];
        rst_n     = 1'b0;
        in_valid  = '0;
        in_data   = '0;
        out_ready = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(out_valid == '0, "R1 out_valid after reset", FW'(out_valid), '0);
        chk(in_ready == '1, "R1 in_ready after reset", FW'(in_ready), FW'(5'h1f));

        // R2 R3 R4 R5: sweep every legal (input, destination) pair
        for (int p = 0; p < NP; p++) begin
            for (int x = 0; x < K; x++) begin
                for (int y = 0; y < K; y++) begin
                    if (legal(p, x, y)) begin
                        int e;
                        f0 = mk(x, y, p * 16 + x * 4 + y);
                        e  = exp_port(x, y);
                        put(p, f0);
                        step();
                        in_valid = '0;
                        chk(out_valid == NP'(1 << e), (x != MX) ? "R2 output select" : "R3 output select",
                            FW'(out_valid), FW'(1 << e));
                        chk(outf(e) == f0, "R5 flit contents", outf(e), f0);
                        chk(out_valid[p] == 1'b0, "R4 no exit by arrival port", FW'(out_valid[p]), '0);
                        step();
                        chk(out_valid == '0, "R5 flit leaves when ready", FW'(out_valid), '0);
                    end
                end
            end
        end

        // R6 R7: four inputs contend for the local output
        for (int p = 1; p <= 4; p++) put(p, mk(MX, MY, 16 + p));
        step();
        in_valid = '0;
        for (int s = 1; s <= 4; s++) begin
            chk(out_valid == 5'b00001, "R6 single grant", FW'(out_valid), FW'(5'b00001));
            chk(outf(0) == mk(MX, MY, 16 + s), "R7 rotating order", outf(0), mk(MX, MY, 16 + s));
            step();
        end
        chk(out_valid == '0, "R6 waiting flits all delivered", FW'(out_valid), '0);

        // R8 R7: stalled local output, later higher-priority arrival
        out_ready[0] = 1'b0;
        put(2, mk(MX, MY, 8'h20));
        step();
        in_valid = '0;
        chk(outf(0) == mk(MX, MY, 8'h20), "R8 hold A", outf(0), mk(MX, MY, 8'h20));
        put(1, mk(MX, MY, 8'h10));
        put(2, mk(MX, MY, 8'h21));
        step();
        in_valid = '0;
        chk(out_valid[0] && outf(0) == mk(MX, MY, 8'h20), "R8 hold B", outf(0), mk(MX, MY, 8'h20));
        put(1, mk(MX, MY, 8'h11));
        step();
        in_valid = '0;
        chk(out_valid[0] && outf(0) == mk(MX, MY, 8'h20), "R8 hold C", outf(0), mk(MX, MY, 8'h20));
        step();
        chk(out_valid[0] && outf(0) == mk(MX, MY, 8'h20), "R8 hold D", outf(0), mk(MX, MY, 8'h20));
        order[0] = mk(MX, MY, 8'h20);
        order[1] = mk(MX, MY, 8'h10);
        order[2] = mk(MX, MY, 8'h21);
        order[3] = mk(MX, MY, 8'h11);
        out_ready[0] = 1'b1;
        for (int s = 0; s < 4; s++) begin
            chk(out_valid[0] && outf(0) == order[s], "R7 fair release order", outf(0), order[s]);
            step();
        end
        chk(out_valid == '0, "R7 queue drained", FW'(out_valid), '0);

        // R9: fill input 3 toward a stalled -Y output
        f0 = mk(MX, 0, 8'h30);
        f1 = mk(MX, 0, 8'h31);
        f2 = mk(MX, 0, 8'h32);
        out_ready[4] = 1'b0;
        put(3, f0);
        step();
        chk(in_ready[3] == 1'b1, "R9 room after one", FW'(in_ready[3]), FW'(1));
        put(3, f1);
        step();
        chk(in_ready[3] == 1'b0, "R9 full drops ready", FW'(in_ready[3]), '0);
        put(3, f2);
        step();
        chk(in_ready[3] == 1'b0 && outf(4) == f0, "R9 still full, head kept", outf(4), f0);
        out_ready[4] = 1'b1;
        chk(out_valid[4] && outf(4) == f0, "R9 first flit", outf(4), f0);
        step();
        chk(out_valid[4] && outf(4) == f1, "R9 second flit", outf(4), f1);
        chk(in_ready[3] == 1'b1, "R9 ready returns", FW'(in_ready[3]), FW'(1));
        step();
        in_valid = '0;
        chk(out_valid[4] && outf(4) == f2, "R9 third flit not dropped", outf(4), f2);
        step();
        chk(out_valid == '0, "R9 drained", FW'(out_valid), '0);

        // R10: two streams through distinct outputs, push and pop every cycle
        for (int c = 0; c < 6; c++) begin
            put(0, mk(3, MY, 8'h40 + c));
            put(1, mk(0, MY, 8'h50 + c));
            step();
            chk(out_valid == 5'b00110, "R10 concurrent outputs", FW'(out_valid), FW'(5'b00110));
            chk(outf(1) == mk(3, MY, 8'h40 + c), "R10 stream +X", outf(1), mk(3, MY, 8'h40 + c));
            chk(outf(2) == mk(0, MY, 8'h50 + c), "R10 stream -X", outf(2), mk(0, MY, 8'h50 + c));
            chk(in_ready == '1, "R10 ready held while streaming", FW'(in_ready), FW'(5'h1f));
        end
        in_valid = '0;
        step();
        chk(out_valid == '0, "R10 streams drained", FW'(out_valid), '0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule